// File: doc/BRIEF.md
# Multi-Line Vertical Sweep Pulse Generator

This block drives one vertical clock output of an image-sensor timing generator with a long, regular pulse train. Its purpose is to empty the vertical shift registers of a CCD before an image is read out. Each pulse period is shaped by three programmable phase positions: the rise point, the fall point and the period length. The period is repeated a programmed number of times, up to 4096.

The frame is split into regions, and each region has its own sweep bit. In an ordinary region the train belongs to a single line. Every HD strobe cuts the running train and starts it again from phase 0, so no pattern outlasts its line. In a region whose sweep bit is set, HD strobes have no effect on the train. The train runs across as many lines as it needs until its repeat count is used up, and the block counts the HD strobes it crosses on the way. The block does not decode region boundaries. A region-start strobe carrying the new region's index is supplied from outside, and the block returns to line-bound operation at the next ordinary region.

Top module: `vsweep_gen`

## Requirements
- R1: After reset, `vout`, `busy` and `done` are 0 and `hd_crossings` is 0.
- R2: On a `region_start` strobe, the block takes the sweep mode from `sweep_en[region_idx]`. An index of 5 or more selects the ordinary mode. On the next cycle a new train starts at phase 0 with repeat 0, and `busy` is 1 when `rep_count` is nonzero.
- R3: The phase counts 0 to `tog3`-1 in each period of a train. `vout` is 1 exactly while `busy` is 1 and `tog1` <= phase < `tog2`.
- R4: A train started with `rep_count` = N (1 to 4096) runs exactly N full periods, and then `busy` falls. With N = 0 no period runs.
- R5: `done` is a one-cycle strobe. It rises in the cycle in which `busy` falls after the final period, or in the cycle after a start with `rep_count` = 0.
- R6: In an ordinary region, after the first `region_start`, each HD strobe restarts the train at phase 0 and repeat 0 with a fresh `rep_count`. This truncates whatever remained of the line's train.
- R7: In a sweep region, HD strobes do not disturb a running train. The phase and the repeat count carry on across line boundaries.
- R8: `hd_crossings` is cleared by `region_start`. It counts each HD strobe that arrives while a sweep-region train is busy, and it saturates at its maximum.
- R9: Once a sweep-region train has finished, the output stays idle through later HD strobes until the next `region_start`. A `region_start` wins over an HD strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| region_start | input | 1 | Strobe marking the first cycle of a new region |
| region_idx | input | 3 | Index of the region that starts with `region_start` |
| sweep_en | input | 5 | Sweep enable, one bit per region 0..4 |
| hd | input | 1 | Horizontal line strobe |
| tog1 | input | 12 | Phase at which `vout` rises |
| tog2 | input | 12 | Phase at which `vout` falls |
| tog3 | input | 12 | Period length in clocks (1..4095) |
| rep_count | input | 13 | Number of periods per train (0..4096) |
| vout | output | 1 | Registered vertical pulse output |
| busy | output | 1 | A train is running |
| done | output | 1 | One-cycle strobe at train completion |
| hd_crossings | output | 13 | HD strobes crossed by the current sweep train |

## Verification
The hardest case to reach is a sweep train with the largest repeat count. Here 4096 periods have to complete while dozens of HD strobes land at arbitrary phases, and not one of those strobes may disturb the phase or the repeat count. The bench drives this case directly with a two-clock period and a fast HD cadence, and counts the rising edges and the crossings at the ports. Randomised trials then vary the sweep bits, the region index (including indices above 4), the toggle positions and the HD spacing. In those trials HD strobes and region starts often fall in the same cycle as the end of a period or of a train, and a cycle-level reference model is compared against the design on every clock.

// File: rtl/vsweep_pkg.sv
package vsweep_pkg;
    localparam int VS_POS_W  = 12;
    localparam int VS_REP_W  = 13;
    localparam int VS_LINE_W = 13;
    localparam int VS_NREG   = 5;

    // Derived width of a region index for a given region count.
    function automatic int idx_width(input int nreg);
        return (nreg > 1) ? $clog2(nreg) : 1;
    endfunction
endpackage

// File: rtl/vsweep_phase.sv
// Phase counter of one pulse period plus the registered waveform decode.
module vsweep_phase #(
    parameter int POS_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             go_next,
    input  logic [POS_W-1:0] tog1,
    input  logic [POS_W-1:0] tog2,
    input  logic [POS_W-1:0] tog3,
    output logic [POS_W-1:0] pos,
    output logic             wrap,
    output logic             vout
);
    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             vout;
    } phase_t;

    phase_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = run && (st_q.pos == (tog3 - POS_W'(1)));
        if (clear) begin
            st_d.pos = '0;
        end else if (run) begin
            st_d.pos = wrap ? '0 : st_q.pos + POS_W'(1);
        end
        st_d.vout = go_next && (st_d.pos >= tog1) && (st_d.pos < tog2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos  = st_q.pos;
    assign vout = st_q.vout;
endmodule

// File: rtl/vsweep_repeat.sv
// Repeat counter: latches the target on a restart and flags the final period.
module vsweep_repeat #(
    parameter int REP_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [REP_W-1:0] load_val,
    input  logic             wrap,
    output logic [REP_W-1:0] reps,
    output logic [REP_W-1:0] target,
    output logic             last
);
    typedef struct packed {
        logic [REP_W-1:0] target;
        logic [REP_W-1:0] reps;
    } rep_t;

    rep_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        last = wrap && ((st_q.reps + REP_W'(1)) == st_q.target);
        if (clear) begin
            st_d.target = load_val;
            st_d.reps   = '0;
        end else if (wrap) begin
            st_d.reps = st_q.reps + REP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reps   = st_q.reps;
    assign target = st_q.target;
endmodule

// File: rtl/vsweep_lines.sv
// Saturating counter of line strobes crossed by a sweep train.
module vsweep_lines #(
    parameter int LINE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              inc,
    output logic [LINE_W-1:0] count
);
    logic [LINE_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)                   cnt_d = '0;
        else if (inc && ~&cnt_q)     cnt_d = cnt_q + LINE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/vsweep_gen.sv
module vsweep_gen
    import vsweep_pkg::*;
#(
    parameter int POS_W  = VS_POS_W,
    parameter int REP_W  = VS_REP_W,
    parameter int LINE_W = VS_LINE_W,
    parameter int NREG   = VS_NREG,
    localparam int IDX_W = idx_width(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              region_start,
    input  logic [IDX_W-1:0]  region_idx,
    input  logic [NREG-1:0]   sweep_en,
    input  logic              hd,
    input  logic [POS_W-1:0]  tog1,
    input  logic [POS_W-1:0]  tog2,
    input  logic [POS_W-1:0]  tog3,
    input  logic [REP_W-1:0]  rep_count,
    output logic              vout,
    output logic              busy,
    output logic              done,
    output logic [LINE_W-1:0] hd_crossings
);
    typedef struct packed {
        logic sweep;
        logic inreg;
        logic active;
        logic done;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    logic             sweep_sel;
    logic             restart;
    logic             wrap;
    logic             last;
    logic             cross_inc;
    logic [POS_W-1:0] pos;
    logic [REP_W-1:0] reps;
    logic [REP_W-1:0] target;

    // Region sweep bit lookup; indices past the last region read as ordinary.
    always_comb begin
        sweep_sel = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            if (region_idx == IDX_W'(i)) sweep_sel = sweep_en[i];
        end
    end

    always_comb begin
        ctl_d     = ctl_q;
        restart   = region_start || (hd && ctl_q.inreg && !ctl_q.sweep);
        cross_inc = hd && ctl_q.sweep && ctl_q.active && !region_start;
        if (region_start) begin
            ctl_d.sweep = sweep_sel;
            ctl_d.inreg = 1'b1;
        end
        if (restart) begin
            ctl_d.active = (rep_count != '0);
            ctl_d.done   = (rep_count == '0);
        end else begin
            ctl_d.done = last;
            if (last) ctl_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    vsweep_phase #(.POS_W(POS_W)) i_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (restart),
        .run     (ctl_q.active),
        .go_next (ctl_d.active),
        .tog1    (tog1),
        .tog2    (tog2),
        .tog3    (tog3),
        .pos     (pos),
        .wrap    (wrap),
        .vout    (vout)
    );

    vsweep_repeat #(.REP_W(REP_W)) i_repeat (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (restart),
        .load_val (rep_count),
        .wrap     (wrap),
        .reps     (reps),
        .target   (target),
        .last     (last)
    );

    vsweep_lines #(.LINE_W(LINE_W)) i_lines (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (region_start),
        .inc   (cross_inc),
        .count (hd_crossings)
    );

    assign busy = ctl_q.active;
    assign done = ctl_q.done;
endmodule

// File: rtl/vsweep_gen_chk.sv
module vsweep_gen_chk #(
    parameter int POS_W  = 12,
    parameter int REP_W  = 13,
    parameter int LINE_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              region_start,
    input logic              hd,
    input logic              sweep_q,
    input logic              inreg_q,
    input logic              busy,
    input logic              done,
    input logic              vout,
    input logic [LINE_W-1:0] hd_crossings,
    input logic [POS_W-1:0]  pos,
    input logic [REP_W-1:0]  reps,
    input logic [REP_W-1:0]  target,
    input logic [REP_W-1:0]  rep_count
);
    // R2
    start_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        region_start && (rep_count != '0) |=> busy && (pos == '0) && (reps == '0));

    // R3
    vout_in_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vout |-> busy);

    // R4
    reps_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (reps < target));

    // R5
    done_ends_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6
    line_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hd && inreg_q && !sweep_q && !region_start && (rep_count != '0)
        |=> busy && (pos == '0) && (reps == '0));

    // R7
    sweep_hd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && sweep_q && hd && !region_start |=> busy || done);

    // R8
    crossings_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        region_start |=> (hd_crossings == '0));
endmodule

bind vsweep_gen vsweep_gen_chk #(
    .POS_W  (POS_W),
    .REP_W  (REP_W),
    .LINE_W (LINE_W)
) i_vsweep_gen_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .region_start (region_start),
    .hd           (hd),
    .sweep_q      (ctl_q.sweep),
    .inreg_q      (ctl_q.inreg),
    .busy         (busy),
    .done         (done),
    .vout         (vout),
    .hd_crossings (hd_crossings),
    .pos          (pos),
    .reps         (reps),
    .target       (target),
    .rep_count    (rep_count)
);

// File: tb/test_vsweep_gen.sv
module test_vsweep_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        region_start = 1'b0;
    logic [2:0]  region_idx = '0;
    logic [4:0]  sweep_en = '0;
    logic        hd = 1'b0;
    logic [11:0] tog1 = 12'd2, tog2 = 12'd5, tog3 = 12'd8;
    logic [12:0] rep_count = 13'd0;
    logic        vout, busy, done;
    logic [12:0] hd_crossings;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int rises = 0;
    logic prev_vout = 1'b0;

    // reference model state
    logic        m_sweep, m_inreg, m_active, m_done, m_vout;
    logic [11:0] m_pos;
    logic [12:0] m_reps, m_target, m_lines;

    always #4 clk = ~clk;

    vsweep_gen i_vsweep_gen (
        .clk(clk), .rst_n(rst_n), .region_start(region_start), .region_idx(region_idx),
        .sweep_en(sweep_en), .hd(hd), .tog1(tog1), .tog2(tog2), .tog3(tog3),
        .rep_count(rep_count), .vout(vout), .busy(busy), .done(done),
        .hd_crossings(hd_crossings)
    );

    function automatic logic sel_sweep(input logic [2:0] idx, input logic [4:0] en);
        return (idx < 3'd5) ? en[idx] : 1'b0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sweep = 0; m_inreg = 0; m_active = 0; m_done = 0; m_vout = 0;
            m_pos = 0; m_reps = 0; m_target = 0; m_lines = 0;
        end else begin
            logic rst_train, wrap, last;
            rst_train = region_start || (hd && m_inreg && !m_sweep);
            wrap = m_active && (m_pos == tog3 - 12'd1);
            last = wrap && (m_reps + 13'd1 == m_target);
            if (region_start) m_lines = 0;
            else if (hd && m_sweep && m_active && m_lines != 13'h1FFF) m_lines = m_lines + 1;
            if (region_start) begin
                m_sweep = sel_sweep(region_idx, sweep_en);
                m_inreg = 1;
            end
            if (rst_train) begin
                m_target = rep_count; m_reps = 0; m_pos = 0;
                m_active = (rep_count != 0); m_done = (rep_count == 0);
            end else begin
                m_done = last;
                if (m_active) begin
                    if (wrap) begin
                        m_pos = 0; m_reps = m_reps + 1;
                        if (last) m_active = 0;
                    end else m_pos = m_pos + 1;
                end
            end
            m_vout = m_active && (m_pos >= tog1) && (m_pos < tog2);
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // One clock: inputs applied now are taken at the next edge; compare at the falling edge.
    task automatic tick();
        @(negedge clk);
        cycles++;
        chk(vout === m_vout, "R3 vout", int'(vout), int'(m_vout));
        chk(busy === m_active, "R4 busy", int'(busy), int'(m_active));
        chk(done === m_done, "R5 done", int'(done), int'(m_done));
        chk(hd_crossings === m_lines, "R8 hd_crossings", int'(hd_crossings), int'(m_lines));
        if (vout && !prev_vout) rises++;
        prev_vout = vout;
        region_start = 0;
        hd = 0;
    endtask

    task automatic start_region(input logic [2:0] idx);
        region_idx = idx;
        region_start = 1;
        tick();
    endtask

    initial begin
        int sd;
        int hd_busy;
        int line_rises;
        int dones;
        sd = int'($urandom(32'd2024));
        #20;
        chk(vout === 0 && busy === 0 && done === 0 && hd_crossings === 0, "R1 reset", int'(busy), 0);
        @(negedge clk);
        rst_n = 1;
        tick();
        chk(busy === 0 && vout === 0, "R1 idle after reset", int'(busy), 0);

        // Sweep region 1: 40 periods of 8 clocks, HD every 50 clocks
        sweep_en = 5'b00010; tog1 = 2; tog2 = 5; tog3 = 8; rep_count = 40;
        rises = 0; hd_busy = 0;
        start_region(3'd1);
        chk(busy === 1, "R2 start busy", int'(busy), 1);
        for (int i = 1; i < 400; i++) begin
            if (i % 50 == 0) begin hd = 1; if (busy) hd_busy++; end
            tick();
        end
        chk(rises == 40, "R4/R7 sweep pulse count", rises, 40);
        chk(hd_crossings == 13'(hd_busy), "R8 lines spanned", int'(hd_crossings), hd_busy);
        chk(hd_busy == 6, "R7 sweep crosses lines", hd_busy, 6);
        // R9: idle through further HD strobes
        for (int i = 0; i < 100; i++) begin
            if (i % 20 == 0) hd = 1;
            tick();
            if (busy !== 0) chk(0, "R9 idle after sweep", int'(busy), 0);
        end
        chk(busy === 0 && vout === 0, "R9 idle after sweep", int'(busy), 0);

        // Ordinary region 0: each HD truncates and restarts, 6 pulses per 50-clock line
        rises = 0; line_rises = 0;
        start_region(3'd0);
        if (vout && !prev_vout) line_rises++;
        line_rises = rises;
        for (int i = 1; i <= 200; i++) begin
            if (i % 50 == 0) begin
                chk(line_rises == 6, "R6 pulses per truncated line", line_rises, 6);
                chk(busy === 1, "R6 train still running at line end", int'(busy), 1);
                line_rises = 0;
                hd = 1;
            end
            rises = 0;
            tick();
            line_rises += rises;
        end
        chk(hd_crossings == 0, "R8 no crossings in ordinary region", int'(hd_crossings), 0);

        // Zero repeats
        rep_count = 0;
        start_region(3'd1);
        chk(done === 1 && busy === 0, "R4/R5 zero repeats", int'(busy), 0);
        tick();
        chk(done === 0, "R5 done is one cycle", int'(done), 0);

        // Index beyond the last region behaves as ordinary
        sweep_en = 5'b11111; rep_count = 100;
        start_region(3'd6);
        for (int i = 0; i < 30; i++) tick();
        hd = 1;
        tick();
        chk(busy === 1 && hd_crossings == 0, "R2 index 6 ordinary", int'(hd_crossings), 0);

        // Maximum repeat count in a sweep region, HD every 300 clocks
        tog1 = 0; tog2 = 1; tog3 = 2; rep_count = 4096; rises = 0; hd_busy = 0; dones = 0;
        start_region(3'd3);
        for (int i = 1; i < 8300; i++) begin
            if (i % 300 == 0) begin hd = 1; if (busy) hd_busy++; end
            tick();
            if (done) dones++;
        end
        chk(rises == 4096, "R4 max repeat count", rises, 4096);
        chk(dones == 1, "R5 single done", dones, 1);
        chk(hd_crossings == 13'(hd_busy), "R8 crossings at max", int'(hd_crossings), hd_busy);

        // Region start and HD in the same cycle
        rep_count = 10; tog1 = 1; tog2 = 3; tog3 = 4;
        hd = 1;
        start_region(3'd3);
        chk(busy === 1 && hd_crossings == 0, "R9 start wins over HD", int'(hd_crossings), 0);
        for (int i = 0; i < 60; i++) tick();

        // Random trials
        for (int t = 0; t < 24; t++) begin
            int hper;
            tog1 = 12'($urandom % 20);
            tog2 = tog1 + 12'(1 + $urandom % 20);
            tog3 = tog2 + 12'($urandom % 10);
            rep_count = 13'(1 + $urandom % 60);
            sweep_en = 5'($urandom);
            hper = 10 + int'($urandom % 200);
            start_region(3'($urandom));
            for (int i = 1; i < 1500; i++) begin
                if (i % hper == 0) hd = 1;
                if ($urandom % 400 == 0) begin region_start = 1; region_idx = 3'($urandom); end
                tick();
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_400_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule